// File: doc/BRIEF.md
# Paged Frame Buffer Host Window

This block gives a host processor byte access to a 512 by 512 frame store of 8-bit pixels through a 64 KB window in its memory space. The frame store is 256 KB, so the host sees one quarter of it at a time. A two-bit page control picks the quarter. A strap input and a control bit together place the window at one of four fixed bases.

An orientation bit picks how a linear offset inside the window lands on a pixel. In horizontal order consecutive offsets walk along a row. In vertical order they walk down a column, which lets software read a column with one linear burst. A RAM-enable control detaches the block from the host bus. While it is clear, every host cycle passes by untouched, so several such blocks can share one window.

Host cycles that hit the window are turned into requests on a synchronous RAM port. The address, write data and strobes on that port are registered. Read data comes back from the RAM one cycle after the request and is registered again before it reaches the host.

Top module: `fbw_host_window`

## Requirements
- R1: While reset is high, and after it, until the first accepted host cycle, ram_req, ram_we, ram_addr, ram_wdata, host_rdata and host_rvalid are all zero.
- R2: A host cycle is inside the window when host_addr[19:16] equals the base nibble picked by {ctl_base_sel, strap_hi}: 00 gives 0xA, 01 gives 0xB, 10 gives 0xD and 11 gives 0xE. A cycle outside the window raises neither ram_req nor host_rvalid.
- R3: While ctl_ram_en is 0, host cycles raise neither ram_req nor host_rvalid, even when they hit the window.
- R4: With ctl_rotate at 0, the RAM address is ctl_page*65536 + host_addr[15:0].
- R5: With ctl_rotate at 1, let L = {ctl_page, host_addr[15:0]} (18 bits). The RAM address is {L[8:0], L[17:9]}, so an offset of x*512+y reaches column x, row y, at RAM address y*512+x.
- R6: An accepted write sets ram_req=1, ram_we=1, ram_wdata=host_wdata and ram_addr to the translated address in the cycle after the request. It never raises host_rvalid.
- R7: An accepted read sets ram_req=1 and ram_we=0 in the cycle after the request. The RAM returns data one cycle later. One cycle after that, host_rvalid is high for exactly one cycle and host_rdata carries that data.
- R8: host_rdata is zero whenever host_rvalid is low.
- R9: When host_rd and host_wr are both high, the cycle is treated as a write and no read data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 20 | Host memory address |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Returned pixel, zero when not valid |
| host_rvalid | output | 1 | Read data valid pulse |
| strap_hi | input | 1 | Board strap: 0 selects the lower base of a pair, 1 the upper |
| ctl_page | input | 2 | Quarter of the frame store shown in the window |
| ctl_rotate | input | 1 | 0 horizontal order, 1 vertical order |
| ctl_base_sel | input | 1 | Base pair select: 0 gives 0xA/0xB, 1 gives 0xD/0xE |
| ctl_ram_en | input | 1 | 1 attaches the frame store to the host bus |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 18 | Pixel address in the frame store |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid the cycle after a read request |

## Verification
The bench goes after the base table by hitting all four bases and the nibbles beside them. A wrong table would let a neighbouring board's window write this frame store, or would leave the block's own window dead. It tries vertical order at the page corners and at the row/column boundary (L[8] and L[9]), where a swapped or off-by-one field split writes the wrong pixel. It also issues cycles with the RAM-enable bit cleared, and with both strobes high. The first catches a block that does not detach from the bus. The second catches one that returns spurious read data. Each read is followed through its two-cycle return, checking that the pulse lands in exactly one cycle and that the data bus is zero outside it.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  // Kind of host cycle accepted into the RAM stage
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/fbw_decode.sv
module fbw_decode #(
  parameter int HADDR_W = 20,
  parameter int OFS_W   = 16,
  parameter int TAG_W   = HADDR_W - OFS_W,
  // four base nibbles, entry index = {base_sel, strap}
  parameter logic [4*TAG_W-1:0] BASE_TABLE = {4'hE, 4'hD, 4'hB, 4'hA}
) (
  input  logic [HADDR_W-1:0] addr,
  input  logic               strap,
  input  logic               base_sel,
  output logic               hit
);
  logic [1:0]       idx;
  logic [TAG_W-1:0] base_tag;

  always_comb begin
    idx      = {base_sel, strap};
    base_tag = BASE_TABLE[idx*TAG_W +: TAG_W];
    hit      = (addr[HADDR_W-1:OFS_W] == base_tag);
  end
endmodule

// File: rtl/fbw_xlate.sv
module fbw_xlate #(
  parameter int DIM_W  = 9,
  parameter int OFS_W  = 16,
  parameter bit ROT_EN = 1'b1,
  localparam int PIX_AW = 2 * DIM_W,
  localparam int PAGE_W = PIX_AW - OFS_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  offset,
  input  logic              rotate,
  output logic [PIX_AW-1:0] pix_addr
);
  logic [PIX_AW-1:0] lin;
  assign lin = {page, offset};

  generate
    if (ROT_EN) begin : g_rot
      // vertical order: low field selects the row, high field the column
      always_comb begin
        if (rotate) pix_addr = {lin[DIM_W-1:0], lin[PIX_AW-1:DIM_W]};
        else        pix_addr = lin;
      end
    end else begin : g_norot
      logic unused_rot;
      assign unused_rot = rotate;
      assign pix_addr   = lin;
    end
  endgenerate
endmodule

// File: rtl/fbw_rdpipe.sv
module fbw_rdpipe #(
  parameter int PIX_W  = 8,
  parameter int RD_LAT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [PIX_W-1:0] ram_rdata,
  output logic [PIX_W-1:0] rdata,
  output logic             rvalid
);
  logic [RD_LAT-1:0] sh;
  logic              ready;

  generate
    if (RD_LAT == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= issue;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[RD_LAT-2:0], issue};
      end
    end
  endgenerate

  assign ready = sh[RD_LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= ready;
      rdata  <= ready ? ram_rdata : '0;
    end
  end
endmodule

// File: rtl/fbw_host_window.sv
module fbw_host_window
  import fbw_pkg::*;
#(
  parameter int HADDR_W = 20,
  parameter int OFS_W   = 16,
  parameter int DIM_W   = 9,
  parameter int PIX_W   = 8,
  parameter int RD_LAT  = 1,
  localparam int TAG_W  = HADDR_W - OFS_W,
  localparam int PIX_AW = 2 * DIM_W,
  localparam int PAGE_W = PIX_AW - OFS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [PIX_W-1:0]   host_wdata,
  output logic [PIX_W-1:0]   host_rdata,
  output logic               host_rvalid,
  input  logic               strap_hi,
  input  logic [PAGE_W-1:0]  ctl_page,
  input  logic               ctl_rotate,
  input  logic               ctl_base_sel,
  input  logic               ctl_ram_en,
  output logic               ram_req,
  output logic               ram_we,
  output logic [PIX_AW-1:0]  ram_addr,
  output logic [PIX_W-1:0]   ram_wdata,
  input  logic [PIX_W-1:0]   ram_rdata
);
  logic              hit;
  logic [PIX_AW-1:0] pix_addr;
  acc_e              acc;

  fbw_decode #(
    .HADDR_W(HADDR_W), .OFS_W(OFS_W), .TAG_W(TAG_W)
  ) i_decode (
    .addr(host_addr), .strap(strap_hi), .base_sel(ctl_base_sel), .hit(hit)
  );

  fbw_xlate #(
    .DIM_W(DIM_W), .OFS_W(OFS_W), .ROT_EN(1'b1)
  ) i_xlate (
    .page(ctl_page), .offset(host_addr[OFS_W-1:0]), .rotate(ctl_rotate),
    .pix_addr(pix_addr)
  );

  // write has priority when both strobes are seen
  always_comb begin
    acc = ACC_NONE;
    if (hit && ctl_ram_en) begin
      if (host_wr)      acc = ACC_WRITE;
      else if (host_rd) acc = ACC_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_req   <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_req <= (acc != ACC_NONE);
      ram_we  <= (acc == ACC_WRITE);
      if (acc != ACC_NONE) ram_addr  <= pix_addr;
      if (acc == ACC_WRITE) ram_wdata <= host_wdata;
    end
  end

  fbw_rdpipe #(
    .PIX_W(PIX_W), .RD_LAT(RD_LAT)
  ) i_rdpipe (
    .clk(clk), .rst(rst), .issue(ram_req && !ram_we),
    .ram_rdata(ram_rdata), .rdata(host_rdata), .rvalid(host_rvalid)
  );
endmodule

// File: rtl/fbw_host_window_chk.sv
module fbw_host_window_chk (
  input logic        clk,
  input logic        rst,
  input logic [19:0] host_addr,
  input logic        host_rd,
  input logic        host_wr,
  input logic [7:0]  host_wdata,
  input logic [7:0]  host_rdata,
  input logic        host_rvalid,
  input logic        ctl_ram_en,
  input logic        ram_req,
  input logic        ram_we
);
  logic outside;
  assign outside = !(host_addr[19:16] inside {4'hA, 4'hB, 4'hD, 4'hE});

  a_r3_detached_no_req: assert property (@(posedge clk) disable iff (rst)
    (host_rd || host_wr) && !ctl_ram_en |=> !ram_req);

  a_r2_outside_no_req: assert property (@(posedge clk) disable iff (rst)
    (host_rd || host_wr) && outside |=> !ram_req);

  a_r7_read_returns: assert property (@(posedge clk) disable iff (rst)
    ram_req && !ram_we |-> ##2 host_rvalid);

  a_r6_write_no_return: assert property (@(posedge clk) disable iff (rst)
    ram_req && ram_we |-> ##2 !host_rvalid);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    host_rvalid && !$past(ram_req && !ram_we, 2) |-> 1'b0);

  a_r8_idle_data_zero: assert property (@(posedge clk) disable iff (rst)
    !host_rvalid |-> host_rdata == 8'h00);

  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    host_rd && host_wr |=> !ram_req || ram_we);

  a_r6_wdata_follows: assert property (@(posedge clk) disable iff (rst)
    ram_req && ram_we |-> $past(host_wr));
endmodule

bind fbw_host_window fbw_host_window_chk i_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
  .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .host_rvalid(host_rvalid), .ctl_ram_en(ctl_ram_en),
  .ram_req(ram_req), .ram_we(ram_we)
);

// File: tb/test_fbw_host_window.sv
module test_fbw_host_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        strap_hi = 1'b0;
  logic [1:0]  ctl_page = '0;
  logic        ctl_rotate = 1'b0, ctl_base_sel = 1'b0, ctl_ram_en = 1'b0;
  logic        ram_req, ram_we;
  logic [17:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fbw_host_window i_fbw_host_window (.*);

  function automatic logic [7:0] pat(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'h5A;
  endfunction

  // RAM model: one-cycle synchronous read of a computed pattern
  always_ff @(posedge clk)
    if (ram_req && !ram_we) ram_rdata <= pat(ram_addr);

  function automatic logic [3:0] exp_base(input logic sel, input logic strap);
    case ({sel, strap})
      2'b00: return 4'hA;
      2'b01: return 4'hB;
      2'b10: return 4'hD;
      default: return 4'hE;
    endcase
  endfunction

  function automatic logic [17:0] exp_addr(input logic [1:0] pg,
      input logic [15:0] ofs, input logic rot);
    logic [8:0] hi, lo;
    {hi, lo} = {pg, ofs};
    return rot ? {lo, hi} : {hi, lo};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input bit rd, input bit wr, input logic [19:0] a,
      input logic [7:0] d, input logic [1:0] pg, input bit rot,
      input bit sel, input bit strap, input bit en, input string mtag);
    bit acc, exp_rv;
    logic [17:0] ea;
    acc = (rd || wr) && en && (a[19:16] == exp_base(sel, strap));
    ea  = exp_addr(pg, a[15:0], rot);
    exp_rv = acc && rd && !wr;
    host_addr = a; host_rd = rd; host_wr = wr; host_wdata = d;
    ctl_page = pg; ctl_rotate = rot; ctl_base_sel = sel; strap_hi = strap;
    ctl_ram_en = en;
    @(negedge clk);
    chk(ram_req == acc, en ? "R2 ram_req" : "R3 ram_req", ram_req, acc);
    if (acc) begin
      chk(ram_we == wr, wr && rd ? "R9 ram_we" : "R6/R7 ram_we", ram_we, wr);
      chk(ram_addr == ea, {mtag, " ram_addr"}, ram_addr, ea);
      if (wr) chk(ram_wdata == d, "R6 ram_wdata", ram_wdata, d);
    end
    host_rd = 1'b0; host_wr = 1'b0;
    @(negedge clk);
    chk(host_rvalid == 1'b0, "R7 early rvalid", host_rvalid, 0);
    @(negedge clk);
    chk(host_rvalid == exp_rv, "R7 rvalid", host_rvalid, exp_rv);
    if (exp_rv) chk(host_rdata == pat(ea), "R7 rdata", host_rdata, pat(ea));
    else        chk(host_rdata == 8'h00, "R8 rdata idle", host_rdata, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(ram_req == 0 && ram_we == 0 && host_rvalid == 0, "R1 strobes in reset",
        {ram_req, ram_we, host_rvalid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ram_addr == 0 && ram_wdata == 0 && host_rdata == 0, "R1 data after reset",
        ram_addr ^ ram_wdata ^ host_rdata, 0);

    // R2: every base, plus the nibbles around it
    for (int s = 0; s < 4; s++) begin
      logic [3:0] b;
      b = exp_base(s[1], s[0]);
      op(0, 1, {b, 16'h1234}, 8'h11 + 8'(s), 2'd1, 0, s[1], s[0], 1, "R2");
      op(1, 0, {b, 16'hFFFF}, 8'h00, 2'd3, 0, s[1], s[0], 1, "R2");
      op(0, 1, {b + 4'd1, 16'h0000}, 8'h22, 2'd0, 0, s[1], s[0], 1, "R2");
      op(1, 0, {b - 4'd1, 16'h0000}, 8'h00, 2'd0, 0, s[1], s[0], 1, "R2");
    end
    // R3: detached from bus
    op(0, 1, 20'hE0010, 8'h77, 2'd2, 0, 1, 1, 0, "R3");
    op(1, 0, 20'hA0010, 8'h00, 2'd0, 1, 0, 0, 0, "R3");
    // R4: horizontal corners
    op(0, 1, 20'hD0000, 8'h01, 2'd0, 0, 1, 0, 1, "R4");
    op(1, 0, 20'hDFFFF, 8'h00, 2'd3, 0, 1, 0, 1, "R4");
    // R5: vertical, column 5 row 7 and field boundaries
    op(0, 1, 20'hE0000 + 20'(5*512 + 7), 8'h3C, 2'd0, 1, 1, 1, 1, "R5");
    op(1, 0, 20'hE0001, 8'h00, 2'd2, 1, 1, 1, 1, "R5");
    op(1, 0, 20'hE01FF, 8'h00, 2'd1, 1, 1, 1, 1, "R5");
    op(1, 0, 20'hE0200, 8'h00, 2'd1, 1, 1, 1, 1, "R5");
    op(0, 1, 20'hEFFFF, 8'hC3, 2'd3, 1, 1, 1, 1, "R5");
    // R9: both strobes
    op(1, 1, 20'hB4321, 8'h99, 2'd1, 0, 0, 1, 1, "R9");
    op(1, 1, 20'hB4321, 8'h98, 2'd2, 1, 0, 1, 1, "R9");

    for (int i = 0; i < 500; i++) begin
      bit rd, wr, rot, sel, strap, en;
      logic [19:0] a;
      logic [1:0] pg;
      rd = $urandom_range(0, 1); wr = $urandom_range(0, 1);
      rot = $urandom_range(0, 1); sel = $urandom_range(0, 1);
      strap = $urandom_range(0, 1); en = ($urandom_range(0, 7) != 0);
      pg = 2'($urandom_range(0, 3));
      a = 20'($urandom);
      if ($urandom_range(0, 3) != 0) a[19:16] = exp_base(sel, strap);
      op(rd, wr, a, 8'($urandom), pg, rot, sel, strap, en, rot ? "R5" : "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule